// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block programs a target FPGA through its slave serial configuration pins. A host writes bitstream entries into a write-only queue. Each entry holds a 32-bit word, a 2-bit byte count and an end-of-stream flag. The host then sets a start bit. The loader drives the target's program line low, waits for the target's init line to rise, and sends the valid bytes one bit at a time on a data line. The configuration clock is a divided copy of the system clock.

After the final entry, the loader adds a fixed number of extra configuration clocks and waits for the target's done line. It reports the result through done, error and busy status bits. A shared timeout turns a silent init or done line into an error. A software reset returns the loader to idle and empties the queue. An exit bit gives a one-cycle pulse to the surrounding logic.

The register port is a plain word-addressed write strobe with a combinational read. Address 0 is control/status. Address 1 holds the attributes for the next entry. A write to address 2 pushes an entry. Address 3 is queue status and clear.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `cfg_prog_b_o` is 1 and `cfg_cclk_o` is 0. Control (address 0) reads the version parameter in bits 21:14 and zero elsewhere. Queue status (address 3) reads 0x0002_0000, meaning the empty flag in bit 17 is set and the count is 0.
- R2: A write to address 2 pushes {attributes, data}. The attributes come from the last write to address 1: bits 1:0 are the size code, where n means n+1 valid bytes, and bit 2 is the last flag. The count in bits 7:0 of address 3 rises by one per push. With DEPTH entries stored, bit 16 (full) is set and the count field wraps to 0. A push while full is dropped.
- R3: Writing 1 to bit 18 of address 3 empties the queue, so status reads 0x0002_0000.
- R4: Writing 1 to bit 0 of control while idle holds `cfg_prog_b_o` low for PROG_LEN cycles. The loader then waits for `cfg_init_b_i` high. Busy (bit 3) reads 1 from the start until done or error. A start written while busy has no effect on `cfg_prog_b_o`.
- R5: The configuration clock period is 2·(CLKDIV+1) system cycles, where CLKDIV is control bits 13:8. Data changes only while the clock is low, so it is stable at every rising edge.
- R6: Each entry sends 8·(n+1) bits, most significant bit of each byte first. With control bit 4 = 1, the bytes go from bit 31 downward, so the upper bytes are valid. With bit 4 = 0, the bytes go from byte 0 upward, so the lower bytes are valid.
- R7: After the last bit of the entry flagged last, exactly EXTRA_CLKS more rising clock edges follow. `cfg_done_i` high then sets done (bit 1) and clears busy.
- R8: If `cfg_init_b_i` or `cfg_done_i` stays low for TIMEOUT cycles in its waiting phase, error (bit 2) is set, busy clears and done stays 0.
- R9: Writing 1 to control bit 5 returns the loader to idle at once. It empties the queue, clears done and error, parks the clock low and releases program high.
- R10: Writing 1 to control bit 6 pulses `cfg_exit_o` high for the cycle after the write.
- R11: Every control write stores bit 4 and bits 13:8, and these read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| cfg_prog_b_o | output | 1 | Active-low program request to the target |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_din_o | output | 1 | Serial configuration data |
| cfg_init_b_i | input | 1 | Target init line |
| cfg_done_i | input | 1 | Target done line |
| cfg_exit_o | output | 1 | One-cycle exit pulse |

## Verification
The hardest state to reach is the tail of a run. There, the extra clocks must be counted exactly, and the loader must then wait on a done line that either rises or times out. A behavioural target in the bench records every bit on rising configuration clock edges. It holds init low while program is asserted and raises done only after it has seen the expected number of bits plus the extra clocks, or never raises it in the timeout runs. Random entry sizes, byte orders and dividers come from a fixed seed. Directed runs cover the single-byte entry, a start written mid-run, a silent init line and a software reset in the middle of shifting.

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader #(
  parameter int         DEPTH      = 256,
  parameter logic [7:0] VERSION    = 8'h03,
  parameter int         PROG_LEN   = 16,
  parameter int         EXTRA_CLKS = 16,
  parameter int         TIMEOUT    = 100000
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        cfg_prog_b_o,
  output logic        cfg_cclk_o,
  output logic        cfg_din_o,
  input  logic        cfg_init_b_i,
  input  logic        cfg_done_i,
  output logic        cfg_exit_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PROG_LEN + 1);
  localparam int EW = $clog2(EXTRA_CLKS + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_INIT, S_SHIFT, S_FLUSH} state_t;
  state_t state;

  logic [34:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fifo_cnt;
  logic [2:0]    attr_q;
  logic          msb_q;
  logic [5:0]    clkdiv_q;
  logic          done_q, err_q, loaded, last_q, cclk_q, din_q, prog_b_q, exit_q;
  logic [31:0]   sr;
  logic [5:0]    bits_left;
  logic [5:0]    div_cnt;
  logic [PW-1:0] pcnt;
  logic [EW-1:0] extra;
  logic [TW-1:0] tmr;

  logic wr_ctl, start_p, swrst_p, exit_p, clr_p, push, pop;
  logic fifo_full, fifo_empty, busy, run_clk, tick, timeout;
  logic [34:0] head;
  logic [31:0] arranged;

  assign wr_ctl     = reg_we_i && (reg_addr_i == 2'd0);
  assign start_p    = wr_ctl && reg_wdata_i[0];
  assign swrst_p    = wr_ctl && reg_wdata_i[5];
  assign exit_p     = wr_ctl && reg_wdata_i[6];
  assign clr_p      = reg_we_i && (reg_addr_i == 2'd3) && reg_wdata_i[18];
  assign fifo_full  = fifo_cnt == (AW+1)'(DEPTH);
  assign fifo_empty = fifo_cnt == '0;
  assign push       = reg_we_i && (reg_addr_i == 2'd2) && !fifo_full;
  assign pop        = (state == S_SHIFT) && !loaded && !fifo_empty;
  assign busy       = state != S_IDLE;
  assign head       = mem[rp];
  assign arranged   = msb_q ? head[31:0]
                            : {head[7:0], head[15:8], head[23:16], head[31:24]};
  assign run_clk    = (state == S_SHIFT && loaded) ||
                      (state == S_FLUSH && (extra != '0 || cclk_q));
  assign tick       = run_clk && (div_cnt == clkdiv_q);
  assign timeout    = tmr == TW'(TIMEOUT);

  assign cfg_prog_b_o = prog_b_q;
  assign cfg_cclk_o   = cclk_q;
  assign cfg_din_o    = din_q;
  assign cfg_exit_o   = exit_q;

  always_ff @(posedge clk_i) begin
    if (push) mem[wp] <= {attr_q, reg_wdata_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || swrst_p || clr_p) begin
      wp <= '0;
      rp <= '0;
      fifo_cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fifo_cnt <= fifo_cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      attr_q   <= '0;
      msb_q    <= 1'b0;
      clkdiv_q <= '0;
      exit_q   <= 1'b0;
    end else begin
      exit_q <= exit_p;
      if (reg_we_i && reg_addr_i == 2'd1) attr_q <= reg_wdata_i[2:0];
      if (wr_ctl) begin
        msb_q    <= reg_wdata_i[4];
        clkdiv_q <= reg_wdata_i[13:8];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_clk || tick) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || swrst_p || !(state == S_INIT || state == S_FLUSH)) tmr <= '0;
    else if (!timeout) tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || swrst_p) begin
      state     <= S_IDLE;
      prog_b_q  <= 1'b1;
      cclk_q    <= 1'b0;
      din_q     <= 1'b0;
      loaded    <= 1'b0;
      last_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      sr        <= '0;
      bits_left <= '0;
      pcnt      <= '0;
      extra     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_p) begin
          done_q   <= 1'b0;
          err_q    <= 1'b0;
          prog_b_q <= 1'b0;
          pcnt     <= '0;
          state    <= S_PROG;
        end
        S_PROG: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PW'(PROG_LEN - 1)) begin
            prog_b_q <= 1'b1;
            state    <= S_INIT;
          end
        end
        S_INIT: begin
          if (timeout) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (cfg_init_b_i) begin
            state <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!loaded) begin
            if (!fifo_empty) begin
              loaded    <= 1'b1;
              sr        <= arranged;
              din_q     <= arranged[31];
              last_q    <= head[34];
              bits_left <= {3'({1'b0, head[33:32]}) + 3'd1, 3'b000};
            end
          end else if (tick) begin
            if (!cclk_q) begin
              cclk_q <= 1'b1;
            end else begin
              cclk_q    <= 1'b0;
              sr        <= {sr[30:0], 1'b0};
              din_q     <= sr[30];
              bits_left <= bits_left - 1'b1;
              if (bits_left == 6'd1) begin
                loaded <= 1'b0;
                if (last_q) begin
                  extra <= EW'(EXTRA_CLKS);
                  state <= S_FLUSH;
                end
              end
            end
          end
        end
        S_FLUSH: begin
          if (cfg_done_i) begin
            done_q <= 1'b1;
            cclk_q <= 1'b0;
            state  <= S_IDLE;
          end else if (timeout) begin
            err_q  <= 1'b1;
            cclk_q <= 1'b0;
            state  <= S_IDLE;
          end else if (tick) begin
            if (cclk_q) begin
              cclk_q <= 1'b0;
            end else begin
              cclk_q <= 1'b1;
              extra  <= extra - 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = {10'd0, VERSION, clkdiv_q, 3'd0, msb_q, busy, err_q, done_q, 1'b0};
      2'd3:    reg_rdata_o = {13'd0, 1'b0, fifo_empty, fifo_full, 16'(fifo_cnt[AW-1:0])};
      default: reg_rdata_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/serial_cfg_loader_chk.sv
`timescale 1ns/1ps
module serial_cfg_loader_chk #(
  parameter int DEPTH = 256
) (
  input logic                       clk_i,
  input logic                       rst_i,
  input logic                       reg_we_i,
  input logic [1:0]                 reg_addr_i,
  input logic [31:0]                reg_wdata_i,
  input logic                       cfg_prog_b_o,
  input logic                       cfg_cclk_o,
  input logic                       cfg_din_o,
  input logic                       cfg_exit_o,
  input logic                       busy,
  input logic                       done_q,
  input logic                       err_q,
  input logic [$clog2(DEPTH):0]     fifo_cnt
);
  a_r5_din_stable_at_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cfg_cclk_o) |-> $stable(cfg_din_o));

  a_r5_din_moves_when_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(cfg_din_o) |-> !cfg_cclk_o);

  a_r4_prog_high_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy |-> cfg_prog_b_o);

  a_r5_clock_parked_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy |-> !cfg_cclk_o);

  a_r8_done_error_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(done_q && err_q));

  a_r2_count_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r3_clear_empties: assert property (@(posedge clk_i) disable iff (rst_i)
    (reg_we_i && reg_addr_i == 2'd3 && reg_wdata_i[18]) |=> (fifo_cnt == '0));

  a_r9_swrst_idles: assert property (@(posedge clk_i) disable iff (rst_i)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[5]) |=>
      (!busy && fifo_cnt == '0 && !done_q && !err_q && cfg_prog_b_o && !cfg_cclk_o));

  a_r10_exit_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[6]) |=> cfg_exit_o);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .cfg_prog_b_o(cfg_prog_b_o), .cfg_cclk_o(cfg_cclk_o),
  .cfg_din_o(cfg_din_o), .cfg_exit_o(cfg_exit_o), .busy(busy), .done_q(done_q),
  .err_q(err_q), .fifo_cnt(fifo_cnt)
);

// File: tb/serial_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb_top;
  localparam int PROG_LEN = 6;
  localparam int EXTRA    = 8;
  localparam int TMO      = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic prog_b, cclk, din, exit_o;
  logic init_b = 1'b1;
  logic done_in = 1'b0;

  int checks = 0;
  int errors = 0;
  int cap_n = 0;
  bit cap [0:1023];
  bit exp_b [0:1023];
  time rise_t [0:1];

  always #10 clk = ~clk;

  serial_cfg_loader #(.PROG_LEN(PROG_LEN), .EXTRA_CLKS(EXTRA), .TIMEOUT(TMO)) dut_i (
    .clk_i(clk), .rst_i(rst), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cfg_prog_b_o(prog_b), .cfg_cclk_o(cclk), .cfg_din_o(din),
    .cfg_init_b_i(init_b), .cfg_done_i(done_in), .cfg_exit_o(exit_o));

  always @(posedge cclk) begin
    if (cap_n < 1024) cap[cap_n] = din;
    if (cap_n < 2) rise_t[cap_n] = $time;
    cap_n = cap_n + 1;
  end

  function automatic logic [31:0] ctrl_exp(bit dn, bit er, bit bz, bit msb, int div);
    return {10'd0, 8'h03, 6'(div), 3'd0, msb, bz, er, dn, 1'b0};
  endfunction

  function automatic logic [31:0] send_order(logic [31:0] d, bit msb);
    return msb ? d : {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic do_run(input int n, input int div, input bit msb, input int fsz,
                        input bit give_done, input bit poke_busy);
    int nb = 0;
    int plow = 0;
    int guard = 0;
    int mism = 0;
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d = $urandom;
      int sz = (fsz >= 0) ? fsz : int'($urandom % 4);
      logic [31:0] o = send_order(d, msb);
      wr(2'd1, {29'd0, (i == n-1), 2'(sz)});
      wr(2'd2, d);
      for (int k = 0; k < (sz+1)*8; k++) begin exp_b[nb] = o[31-k]; nb++; end
    end
    done_in = 1'b0; init_b = 1'b0; cap_n = 0;
    wr(2'd0, 32'h1 | (32'(msb) << 4) | (32'(div) << 8));
    while (!prog_b && plow < 1000) begin plow++; @(negedge clk); end
    chk(plow == PROG_LEN, "R4 program low cycles", plow, PROG_LEN);
    rd(2'd0, v);
    chk(v == ctrl_exp(0, 0, 1, msb, div), "R4 busy while waiting init", v, ctrl_exp(0, 0, 1, msb, div));
    if (poke_busy) begin
      wr(2'd0, 32'h1 | (32'(msb) << 4) | (32'(div) << 8));
      repeat (3) @(negedge clk);
      chk(prog_b == 1'b1, "R4 start while busy ignored", prog_b, 1);
    end
    init_b = 1'b1;
    while (cap_n < nb + EXTRA && guard < 20000) begin @(negedge clk); guard++; end
    repeat (4*(div+1) + 4) @(negedge clk);
    chk(cap_n == nb + EXTRA, "R7 extra clock count", cap_n, nb + EXTRA);
    for (int k = 0; k < nb; k++) if (cap[k] != exp_b[k]) mism++;
    chk(mism == 0, "R6 serial bit stream", mism, 0);
    chk((rise_t[1] - rise_t[0]) == time'(40*(div+1)), "R5 clock period",
        32'(rise_t[1] - rise_t[0]), 40*(div+1));
    if (give_done) begin
      done_in = 1'b1;
      repeat (3) @(negedge clk);
      rd(2'd0, v);
      chk(v == ctrl_exp(1, 0, 0, msb, div), "R7 done reported", v, ctrl_exp(1, 0, 0, msb, div));
    end else begin
      guard = 0;
      do begin rd(2'd0, v); guard++; end while (v[3] && guard < 5000);
      chk(v == ctrl_exp(0, 1, 0, msb, div), "R8 done timeout error", v, ctrl_exp(0, 1, 0, msb, div));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int guard;
    int snap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v);
    chk(v == ctrl_exp(0, 0, 0, 0, 0), "R1 control after reset", v, ctrl_exp(0, 0, 0, 0, 0));
    rd(2'd3, v);
    chk(v == 32'h0002_0000, "R1 queue status after reset", v, 32'h0002_0000);
    chk(prog_b == 1'b1 && cclk == 1'b0, "R1 pins after reset", {prog_b, cclk}, 2'b10);

    // R11 readback
    wr(2'd0, 32'h0000_2510);
    rd(2'd0, v);
    chk(v == ctrl_exp(0, 0, 0, 1, 37), "R11 divider and order readback", v, ctrl_exp(0, 0, 0, 1, 37));

    // R2 fill, overflow; R3 clear
    wr(2'd1, 32'h3);
    for (int i = 0; i < 5; i++) wr(2'd2, 32'(i));
    rd(2'd3, v);
    chk(v == 32'h0000_0005, "R2 count after five pushes", v, 32'h5);
    for (int i = 5; i < 256; i++) wr(2'd2, 32'(i));
    rd(2'd3, v);
    chk(v == 32'h0001_0000, "R2 full flag at depth", v, 32'h0001_0000);
    wr(2'd2, 32'hdead);
    rd(2'd3, v);
    chk(v == 32'h0001_0000, "R2 push while full dropped", v, 32'h0001_0000);
    wr(2'd3, 32'h0004_0000);
    rd(2'd3, v);
    chk(v == 32'h0002_0000, "R3 clear empties queue", v, 32'h0002_0000);

    // directed corners then random runs (R4 R5 R6 R7 R8)
    do_run(1, 0, 1'b0, 0, 1'b1, 1'b1);
    do_run(3, 3, 1'b1, 3, 1'b1, 1'b0);
    do_run(2, 1, 1'b1, 1, 1'b0, 1'b0);
    for (int r = 0; r < 8; r++)
      do_run(1 + int'($urandom % 6), int'($urandom % 4), 1'($urandom), -1, 1'($urandom % 4 != 0), 1'b0);

    // R8 init never rises
    init_b = 1'b0; cap_n = 0;
    wr(2'd0, 32'h1);
    guard = 0;
    do begin rd(2'd0, v); guard++; end while (v[3] && guard < 5000);
    chk(v == ctrl_exp(0, 1, 0, 0, 0), "R8 init timeout error", v, ctrl_exp(0, 1, 0, 0, 0));
    chk(cap_n == 0 && prog_b == 1'b1, "R8 no clocks on init timeout", cap_n, 0);

    // R9 software reset mid-shift
    wr(2'd1, 32'h3);
    for (int i = 0; i < 3; i++) wr(2'd2, $urandom);
    init_b = 1'b0; cap_n = 0;
    wr(2'd0, 32'h0000_0301);
    repeat (PROG_LEN + 2) @(negedge clk);
    init_b = 1'b1;
    guard = 0;
    while (cap_n < 10 && guard < 5000) begin @(negedge clk); guard++; end
    wr(2'd0, 32'h0000_0020);
    rd(2'd0, v);
    chk(v == ctrl_exp(0, 0, 0, 0, 0), "R9 reset returns idle", v, ctrl_exp(0, 0, 0, 0, 0));
    rd(2'd3, v);
    chk(v == 32'h0002_0000, "R9 reset flushes queue", v, 32'h0002_0000);
    snap = cap_n;
    repeat (60) @(negedge clk);
    chk(cap_n == snap && cclk == 1'b0 && prog_b == 1'b1, "R9 clock stopped after reset", cap_n, snap);

    // R10 exit pulse
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 32'h40;
    @(negedge clk); we = 1'b0; wdata = 32'd0;
    chk(exit_o == 1'b1, "R10 exit pulse high", exit_o, 1);
    @(negedge clk);
    chk(exit_o == 1'b0, "R10 exit pulse one cycle", exit_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule